// File: doc/BRIEF.md
# Timer Channel with GPIO and Single-Shot Input Capture

This block is one channel of a multi-mode timer. A 7-bit mode code selects one of three behaviours:

- **General-purpose input.** The channel watches a pin and raises a flag on programmed edges.
- **General-purpose output.** The channel drives a pin level from a control bit.
- **Single-shot input capture.** A qualifying pin edge latches a 16-bit time value into a data register and raises the flag.

The time value comes either from the channel's own free-running counter or from an external counter bus. Software reaches the channel through a small register port with a write strobe, a 3-bit address and combinational read data.

The data registers are two-stage. Stage one (`A1`, `B1`) is written by software. Stage two (`A2`, `B2`) is what the channel uses and what the `A` address returns. In the two GPIO modes a data write fills both stages, the local counter is held at zero, and capture is off. Software is expected to pass through a GPIO mode whenever it changes mode. Capture is armed as soon as the capture mode code is written.

The pin passes through a synchroniser chain and then an optional two-sample glitch filter before edge detection. The register port is plain control traffic, so there is no valid/ready handshake. A write completes at the clock edge on which `wr_en_i` is sampled high, and reads are combinational from the address. A pin held high through reset produces one rising edge after reset.

Top module: `tmr_chan_capture`

## Requirements

- R1: The mode field is control bits [6:0]. Code 0 is GPIO input, code 1 is GPIO output and code 2 is capture. Any other code sets no flag and captures nothing.
- R2: The local counter is held at 0 on every clock at which the registered mode is 0 or 1. In any other mode it adds 1 per clock. After the clock that writes the capture code from a GPIO mode, its value is 0.
- R3: Data write addresses are A=0 and B=1. In a GPIO mode, a write to A loads A1 and A2, and a write to B loads B1 and B2. In any other mode, such a write loads only A1 or B1.
- R4: A write to address 2 (alternate A) loads only A2, in every mode.
- R5: Reads at each address:
  - address 0 returns A2
  - address 1 returns B1
  - address 2 returns A1
  - address 3 returns the control word in bits [11:0]
  - address 4 returns the status: flag in bit 0, filtered pin level in bit 1
  - address 5 returns B2
- R6: In GPIO output mode, `out_pin_o` takes control bit 7 (edge polarity) one clock after each clock edge. In every other mode, `out_pin_o` holds its last value. It resets to 0.
- R7: Control bit 8 = 1 makes both edges qualify. Otherwise, bit 7 = 1 selects rising edges and bit 7 = 0 selects falling edges.
- R8: A qualifying edge sets the flag in GPIO input and capture modes only. It never sets the flag in GPIO output mode.
- R9: In capture mode, a qualifying edge loads A2 with the selected time base on the same clock that sets the flag. Control bit 9 = 1 selects `ext_tb_i`; bit 9 = 0 selects the local counter. With the filter bypassed, a pin change made after clock k is captured at clock k+3 with the counter value k+2, counting from the clock that wrote the capture code.
- R10: Writing status (address 4) with bit 0 = 1 clears the flag, and writing bit 0 = 0 leaves it. When an edge and a clear fall on the same clock, the flag stays set.
- R11: When control bit 10 = 0, the level must hold for two consecutive synchronised samples to pass, which adds two clocks of latency (capture value k+4) and rejects one-clock pulses. When bit 10 = 1, the synchroniser output goes straight to the edge detector.
- R12: `irq_o` is the flag ANDed with control bit 11. `flag_o` shows the flag directly.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous pin input |
| ext_tb_i | input | TB_W | External time-base bus |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for reads and writes |
| wdata_i | input | TB_W | Write data |
| rdata_o | output | TB_W | Read data for `addr_i` |
| out_pin_o | output | 1 | Output flip-flop level |
| flag_o | output | 1 | Event flag |
| irq_o | output | 1 | Flag gated by interrupt enable |

## Verification

A counter that is not cleared on entry from GPIO shows up as a captured value offset from the arithmetic expectation at the first capture. This appears within a few clocks of the pin edge. A data stage that is not mirrored, or that is overwritten, shows up on the very next read of the A, alternate-A, B or B2 view.

A wrong edge qualifier or a lost flag update is visible on the status read and on `irq_o` within three clocks of the pin change, or five clocks when the filter is on. The bench sweeps every combination of polarity, both-edge select, edge direction, filter bypass and the two flag-capable modes. It also checks the exact counter values and a clear that collides with an event.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int MODE_W = 7;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 12;

  localparam logic [MODE_W-1:0] MD_GPIO_IN  = 7'd0;
  localparam logic [MODE_W-1:0] MD_GPIO_OUT = 7'd1;
  localparam logic [MODE_W-1:0] MD_CAPTURE  = 7'd2;

  typedef enum logic [ADDR_W-1:0] {
    RA_DATA_A = 3'd0,
    RA_DATA_B = 3'd1,
    RA_ALT_A  = 3'd2,
    RA_CTRL   = 3'd3,
    RA_STAT   = 3'd4,
    RA_B2     = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic              irq_en;
    logic              filt_byp;
    logic              tb_ext;
    logic              edge_both;
    logic              edge_pol;
    logic [MODE_W-1:0] mode;
  } ctrl_t;
endpackage

// File: rtl/tcc_edge_front.sv
module tcc_edge_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic bypass_i,
  input  logic pol_i,
  input  logic both_i,
  output logic level_o,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic smp, smp_q, filt_q, lvl_q, rise, fall;

  // synchroniser chain, one flop per stage
  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
    end
  end

  assign smp = sync_q[SYNC_STAGES-1];

  // two-sample agreement filter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      filt_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      smp_q <= smp;
      if (smp == smp_q) filt_q <= smp;
      lvl_q <= level_o;
    end
  end

  assign level_o = bypass_i ? smp : filt_q;
  assign rise    = level_o & ~lvl_q;
  assign fall    = ~level_o & lvl_q;

  always_comb begin
    if (both_i)     evt_o = rise | fall;
    else if (pol_i) evt_o = rise;
    else            evt_o = fall;
  end
endmodule

// File: rtl/tcc_local_counter.sv
module tcc_local_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (hold_i) cnt_o <= '0;
    else             cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/tcc_data_buf.sv
module tcc_data_buf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gpio_i,
  input  logic         wr_a_i,
  input  logic         wr_b_i,
  input  logic         wr_alt_i,
  input  logic [W-1:0] wdata_i,
  input  logic         cap_i,
  input  logic [W-1:0] cap_val_i,
  output logic [W-1:0] a1_o,
  output logic [W-1:0] a2_o,
  output logic [W-1:0] b1_o,
  output logic [W-1:0] b2_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1_o <= '0;
      a2_o <= '0;
      b1_o <= '0;
      b2_o <= '0;
    end else begin
      if (wr_a_i) a1_o <= wdata_i;
      if (wr_b_i) b1_o <= wdata_i;
      if (wr_b_i && gpio_i) b2_o <= wdata_i;
      if (cap_i)                  a2_o <= cap_val_i;
      else if (wr_alt_i)          a2_o <= wdata_i;
      else if (wr_a_i && gpio_i)  a2_o <= wdata_i;
    end
  end
endmodule

// File: rtl/tmr_chan_capture.sv
module tmr_chan_capture
  import tcc_pkg::*;
#(
  parameter int TB_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic [TB_W-1:0]   ext_tb_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TB_W-1:0]   wdata_i,
  output logic [TB_W-1:0]   rdata_o,
  output logic              out_pin_o,
  output logic              flag_o,
  output logic              irq_o
);
  ctrl_t ctrl_q;
  logic is_gpio_in, is_gpio_out, is_gpio, is_cap;
  logic level, evt, flag_evt, cap_evt, clr_req;
  logic wr_a, wr_b, wr_alt;
  logic [TB_W-1:0] cnt, tb_sel, a1, a2, b1, b2;

  assign is_gpio_in  = (ctrl_q.mode == MD_GPIO_IN);
  assign is_gpio_out = (ctrl_q.mode == MD_GPIO_OUT);
  assign is_gpio     = is_gpio_in | is_gpio_out;
  assign is_cap      = (ctrl_q.mode == MD_CAPTURE);

  assign wr_a    = wr_en_i && (addr_i == RA_DATA_A);
  assign wr_b    = wr_en_i && (addr_i == RA_DATA_B);
  assign wr_alt  = wr_en_i && (addr_i == RA_ALT_A);
  assign clr_req = wr_en_i && (addr_i == RA_STAT) && wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              ctrl_q <= '0;
    else if (wr_en_i && addr_i == RA_CTRL)   ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
  end

  tcc_edge_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .bypass_i (ctrl_q.filt_byp),
    .pol_i    (ctrl_q.edge_pol),
    .both_i   (ctrl_q.edge_both),
    .level_o  (level),
    .evt_o    (evt)
  );

  tcc_local_counter #(.W(TB_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold_i (is_gpio),
    .cnt_o  (cnt)
  );

  assign tb_sel   = ctrl_q.tb_ext ? ext_tb_i : cnt;
  assign flag_evt = evt && (is_gpio_in || is_cap);
  assign cap_evt  = evt && is_cap;

  tcc_data_buf #(.W(TB_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .gpio_i    (is_gpio),
    .wr_a_i    (wr_a),
    .wr_b_i    (wr_b),
    .wr_alt_i  (wr_alt),
    .wdata_i   (wdata_i),
    .cap_i     (cap_evt),
    .cap_val_i (tb_sel),
    .a1_o      (a1),
    .a2_o      (a2),
    .b1_o      (b1),
    .b2_o      (b2)
  );

  // event has priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_o <= 1'b0;
    else if (flag_evt) flag_o <= 1'b1;
    else if (clr_req)  flag_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           out_pin_o <= 1'b0;
    else if (is_gpio_out) out_pin_o <= ctrl_q.edge_pol;
  end

  assign irq_o = flag_o & ctrl_q.irq_en;

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_DATA_A: rdata_o = a2;
      RA_DATA_B: rdata_o = b1;
      RA_ALT_A:  rdata_o = a1;
      RA_CTRL:   rdata_o = TB_W'(ctrl_q);
      RA_STAT:   rdata_o = TB_W'({level, flag_o});
      RA_B2:     rdata_o = b2;
      default:   rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gpio,
  input logic         gpio_out,
  input logic         pol,
  input logic [W-1:0] cnt,
  input logic [W-1:0] a1,
  input logic [W-1:0] a2,
  input logic         wr_a,
  input logic         wr_alt,
  input logic         flag_evt,
  input logic         flag,
  input logic         irq,
  input logic         out_pin
);
  assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gpio && $past(gpio)) |-> cnt == '0);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(gpio) |-> (cnt - $past(cnt)) == W'(1));

  assert_mirror_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_a && gpio && !wr_alt) |-> a1 == a2);

  assert_capture_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_alt) && !$past(wr_a && gpio) && a2 != $past(a2)) |-> flag);

  assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_evt) |-> flag);

  assert_out_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(gpio_out) |-> out_pin == $past(pol));

  assert_irq_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> !irq);
endmodule

bind tmr_chan_capture tcc_checker #(.W(TB_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gpio     (is_gpio),
  .gpio_out (is_gpio_out),
  .pol      (ctrl_q.edge_pol),
  .cnt      (cnt),
  .a1       (a1),
  .a2       (a2),
  .wr_a     (wr_a),
  .wr_alt   (wr_alt),
  .flag_evt (flag_evt),
  .flag     (flag_o),
  .irq      (irq_o),
  .out_pin  (out_pin_o)
);

// File: tb/tmr_chan_capture_test.sv
`timescale 1ns/1ps
module tmr_chan_capture_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b0;
  logic [15:0] ext_tb = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        out_pin, flag, irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmr_chan_capture uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .ext_tb_i(ext_tb),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .out_pin_o(out_pin), .flag_o(flag), .irq_o(irq)
  );

  // ctrl word: irq_en[11] byp[10] tb_ext[9] both[8] pol[7] mode[6:0]
  function automatic logic [15:0] cw(input logic [6:0] md, input bit pol, input bit both,
                                     input bit ext, input bit byp, input bit ien);
    return {4'h0, ien, byp, ext, both, pol, md};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counter timing: pin rises k negedges after the capture-code write
  task automatic cap_timing(input bit byp, input int k, input logic [15:0] exp, input string tag);
    logic [15:0] v;
    pin = 1'b0;
    wr(3, cw(7'd0, 1, 0, 0, byp, 0));
    idle(8);
    wr(4, 16'h1);
    wr(3, cw(7'd2, 1, 0, 0, byp, 0));
    idle(k);
    pin = 1'b1;
    idle(8);
    rd(0, v); chk(tag, v, exp);
    rd(4, v); chk({tag, " flag"}, {15'd0, v[0]}, 16'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int idx;
    idle(3); rst_n = 1'b1;

    // reset state
    rd(3, v); chk("R5 reset ctrl", v, 16'h0);
    rd(4, v); chk("R5 reset status", v, 16'h0);
    rd(0, v); chk("R3 reset A", v, 16'h0);
    chk("R6 reset out", {15'd0, out_pin}, 16'd0);
    chk("R12 reset irq", {15'd0, irq}, 16'd0);

    // data register staging in GPIO and in capture mode
    wr(0, 16'h1111);
    rd(0, v); chk("R3 gpio A2", v, 16'h1111);
    rd(2, v); chk("R3 gpio A1", v, 16'h1111);
    wr(2, 16'h2222);
    rd(0, v); chk("R4 alt A2", v, 16'h2222);
    rd(2, v); chk("R4 alt keeps A1", v, 16'h1111);
    wr(1, 16'h3333);
    rd(1, v); chk("R3 gpio B1", v, 16'h3333);
    rd(5, v); chk("R5 gpio B2", v, 16'h3333);
    wr(3, cw(7'd2, 1, 0, 1, 1, 0));
    rd(3, v); chk("R5 ctrl readback", v, cw(7'd2, 1, 0, 1, 1, 0));
    wr(0, 16'h4444);
    rd(0, v); chk("R3 cap A2 kept", v, 16'h2222);
    rd(2, v); chk("R3 cap A1", v, 16'h4444);
    wr(1, 16'h5555);
    rd(1, v); chk("R3 cap B1", v, 16'h5555);
    rd(5, v); chk("R3 cap B2 kept", v, 16'h3333);
    wr(2, 16'h6666);
    rd(0, v); chk("R4 cap alt A2", v, 16'h6666);
    wr(3, cw(7'd0, 0, 0, 0, 1, 0));

    // sweep: mode x pol x both x direction x bypass
    idx = 0;
    for (int md = 0; md < 2; md++)
      for (int pol = 0; pol < 2; pol++)
        for (int both = 0; both < 2; both++)
          for (int rise = 0; rise < 2; rise++)
            for (int byp = 0; byp < 2; byp++) begin
              logic [6:0] mcode;
              bit fire;
              logic [15:0] seed;
              mcode = (md == 1) ? 7'd2 : 7'd0;
              seed  = 16'h0100 + 16'(idx);
              pin = (rise == 1) ? 1'b0 : 1'b1;
              wr(3, cw(7'd0, pol[0], both[0], 1, byp[0], 0));
              idle(8);
              wr(0, seed);
              wr(3, cw(mcode, pol[0], both[0], 1, byp[0], 0));
              wr(4, 16'h1);
              ext_tb = 16'hA000 + 16'(idx);
              @(negedge clk); pin = ~pin;
              idle(8);
              fire = (both == 1) || ((rise == 1) ? (pol == 1) : (pol == 0));
              rd(4, v); chk("R7 R8 sweep flag", {15'd0, v[0]}, {15'd0, fire});
              chk("R11 sweep level", {15'd0, v[1]}, {15'd0, pin});
              rd(0, v);
              chk("R9 sweep capture", v, (md == 1 && fire) ? ext_tb : seed);
              idx++;
            end

    // R9 and R2: counter values, bypass and filtered, and restart from 0
    cap_timing(1, 5, 16'd7, "R9 counter capture bypass");
    cap_timing(1, 5, 16'd7, "R2 counter restart");
    cap_timing(0, 5, 16'd9, "R11 counter capture filtered");
    cap_timing(1, 0, 16'd2, "R9 counter capture k0");

    // R11: one-clock glitch rejected by filter, passed when bypassed
    pin = 1'b0;
    wr(3, cw(7'd0, 1, 0, 0, 0, 0)); idle(8); wr(4, 16'h1);
    @(negedge clk); pin = 1'b1; @(negedge clk); pin = 1'b0;
    idle(8);
    rd(4, v); chk("R11 glitch filtered", {15'd0, v[0]}, 16'd0);
    wr(3, cw(7'd0, 1, 0, 0, 1, 0)); idle(8); wr(4, 16'h1);
    @(negedge clk); pin = 1'b1; @(negedge clk); pin = 1'b0;
    idle(8);
    rd(4, v); chk("R11 glitch bypassed", {15'd0, v[0]}, 16'd1);

    // R10: clear on the same cycle as an event
    wr(3, cw(7'd0, 0, 1, 0, 1, 0)); idle(8); wr(4, 16'h1);
    @(negedge clk); pin = ~pin;
    @(negedge clk); @(negedge clk);
    wr_en = 1'b1; addr = 3'd4; wdata = 16'h1;
    @(negedge clk); wr_en = 1'b0;
    chk("R10 event wins over clear", {15'd0, flag}, 16'd1);
    wr(4, 16'h0);
    chk("R10 write zero keeps flag", {15'd0, flag}, 16'd1);
    wr(4, 16'h1);
    chk("R10 clear", {15'd0, flag}, 16'd0);

    // R12: interrupt gating
    wr(3, cw(7'd0, 0, 1, 0, 1, 1));
    @(negedge clk); pin = ~pin; idle(6);
    chk("R12 irq enabled", {15'd0, irq}, 16'd1);
    wr(3, cw(7'd0, 0, 1, 0, 1, 0));
    chk("R12 irq disabled", {15'd0, irq}, 16'd0);
    chk("R12 flag_o", {15'd0, flag}, 16'd1);

    // R6 and R8: GPIO output
    wr(3, cw(7'd1, 1, 1, 0, 1, 0)); idle(3);
    chk("R6 out follows pol=1", {15'd0, out_pin}, 16'd1);
    wr(4, 16'h1);
    @(negedge clk); pin = ~pin; idle(6);
    chk("R8 no flag in gpio out", {15'd0, flag}, 16'd0);
    wr(3, cw(7'd1, 0, 1, 0, 1, 0)); idle(3);
    chk("R6 out follows pol=0", {15'd0, out_pin}, 16'd0);
    wr(3, cw(7'd0, 1, 1, 0, 1, 0)); idle(3);
    chk("R6 out holds in gpio in", {15'd0, out_pin}, 16'd0);

    // R1: unsupported code sets no flag and captures nothing
    wr(0, 16'h7777);
    wr(3, cw(7'd5, 1, 1, 1, 1, 0));
    wr(4, 16'h1);
    ext_tb = 16'hBEEF;
    @(negedge clk); pin = ~pin; idle(6);
    chk("R1 other mode no flag", {15'd0, flag}, 16'd0);
    rd(0, v); chk("R1 other mode no capture", v, 16'h7777);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule